// File: doc/BRIEF.md
# Column Filter State Line Store

A column-direction 1-D wavelet datapath normally keeps its history in K delay registers. When that datapath walks across an image line one column at a time, every column needs its own copy of those registers. This block holds that history. It keeps one set of K state words for each of the LINE_W column positions, so each column carries its filter state from one line pair to the next. The block works the same way whether the datapath is convolution-based or lifting-based.

Every column position owns K words inside a single simple dual-port memory of K*LINE_W words. A rotating column pointer and a phase counter form the addresses. A `col_go` strobe starts a K-cycle read burst for the next column. K+1 cycles after that strobe, the K state words appear together on `st_rd` for one cycle. The datapath returns its updated words on `wb_data` in that same cycle. They are then written back, one word per cycle, through the write port.

A first-line flag makes the block present zero state, so the memory never has to be cleared. A small hold register keeps the most recent write-back. It forwards that value when a column is read again before its write burst has finished.

Top module: `col_state_buffer`

## Requirements
- R1: After reset, `st_vld` is low and `st_rd` is all zero, and the first accepted `col_go` addresses column 0.
- R2: Each `col_go` takes the next column index, which counts up by one and wraps from LINE_W-1 to 0. `st_col` reports the column whose state is being presented.
- R3: `st_vld` is high for exactly one cycle, K+1 cycles after the clock edge that accepted `col_go`. `col_go` may be repeated every K+1 cycles.
- R4: With `col_first` low, slot i of `st_rd` (bits [i*DATA_W +: DATA_W]) equals the slot-i word written back on the most recent earlier visit to that column that had a write-back. Columns and slots are independent. Slot i of column c is stored at word i*LINE_W+c of one shared memory of K*LINE_W words.
- R5: When `col_first` is high with `col_go`, every slot of that visit is presented as zero, whatever is stored. A write-back during that visit is still stored.
- R6: `wb_vld` is sampled only in the `st_vld` cycle. `wb_vld` high in any other cycle, or `wb_vld` low in the `st_vld` cycle, leaves every column's state unchanged.
- R7: When a column is visited again before the write burst of its previous visit has finished, the presented state is the most recently written-back value. This happens with LINE_W=1 at full cadence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_go | input | 1 | Start fetching the state of the next column |
| col_first | input | 1 | Present zero state for this visit (first line pair) |
| st_vld | output | 1 | State words on `st_rd` are valid this cycle |
| st_col | output | max(1,clog2(LINE_W)) | Column index of the presented state |
| st_rd | output | K*DATA_W | K state words, slot i in bits [i*DATA_W +: DATA_W] |
| wb_vld | input | 1 | Updated state present on `wb_data` (used in the `st_vld` cycle only) |
| wb_data | input | K*DATA_W | K updated state words, same slot packing as `st_rd` |

## Verification
A K-tap recursive test datapath is closed around the block, and its state is mirrored by a per-column model in the bench. The first pattern is a run of first-line visits. These separate zero presentation from stored data. Several full line passes then follow, and these tell apart correct per-column, per-slot addressing from aliasing between columns or between slots. Stray write-backs outside the valid cycle, and skipped write-backs, show whether anything other than an accepted write-back changes state. A second instance with a one-column line, driven at full cadence, revisits the same column before its write burst has finished. This isolates the forwarding path from the plain memory read.

// File: rtl/colst_pkg.sv
package colst_pkg;

  // Bit width needed to index n items (at least one bit).
  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Location of state slot idx for column col in the merged memory.
  function automatic int slot_addr(input int idx, input int col, input int line_w);
    return idx * line_w + col;
  endfunction

  // Increment with wrap at lim.
  function automatic int wrap_inc(input int v, input int lim);
    return (v >= lim - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/colst_ram.sv
module colst_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 24,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Write port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port: a read of an address written in the same cycle returns the old word.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/colst_seq.sv
module colst_seq
  import colst_pkg::*;
#(
  parameter int K      = 3,
  parameter int LINE_W = 8,
  parameter int CW     = 3,
  parameter int AW     = 5,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_go,
  input  logic          col_first,
  input  logic          wb_fire,
  input  logic [CW-1:0] wb_col,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_phase,
  output logic [CW-1:0] rd_col,
  output logic          rd_first,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_phase
);

  localparam int DEPTH = K * LINE_W;
  localparam logic [PW-1:0] LAST_PH = PW'(K - 1);

  logic          rd_busy;
  logic [PW-1:0] rd_phase_q;
  logic [CW-1:0] rd_col_q;
  logic          rd_first_q;
  logic [CW-1:0] base_q;
  logic          wr_busy;
  logic [PW-1:0] wr_phase_q;
  logic [CW-1:0] wr_col_q;

  // Rotating column pointer and the read burst, one slot per cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy    <= 1'b0;
      rd_phase_q <= '0;
      rd_col_q   <= '0;
      rd_first_q <= 1'b0;
      base_q     <= '0;
    end else if (col_go) begin
      rd_busy    <= 1'b1;
      rd_phase_q <= '0;
      rd_col_q   <= base_q;
      rd_first_q <= col_first;
      base_q     <= CW'(wrap_inc(int'(base_q), LINE_W));
    end else if (rd_busy) begin
      if (rd_phase_q == LAST_PH) rd_busy <= 1'b0;
      else                       rd_phase_q <= rd_phase_q + 1'b1;
    end
  end

  // Write burst started by an accepted write-back.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy    <= 1'b0;
      wr_phase_q <= '0;
      wr_col_q   <= '0;
    end else if (wb_fire) begin
      wr_busy    <= 1'b1;
      wr_phase_q <= '0;
      wr_col_q   <= wb_col;
    end else if (wr_busy) begin
      if (wr_phase_q == LAST_PH) wr_busy <= 1'b0;
      else                       wr_phase_q <= wr_phase_q + 1'b1;
    end
  end

  assign rd_en    = rd_busy;
  assign rd_phase = rd_phase_q;
  assign rd_col   = rd_col_q;
  assign rd_first = rd_first_q;
  assign rd_addr  = AW'(slot_addr(int'(rd_phase_q), int'(rd_col_q), LINE_W));
  assign wr_en    = wr_busy;
  assign wr_phase = wr_phase_q;
  assign wr_addr  = AW'(slot_addr(int'(wr_phase_q), int'(wr_col_q), LINE_W));

  // R3
  go_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> !rd_busy);

  // R6
  wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> !wr_busy);

  // R4
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < DEPTH));

  // R4
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/colst_gather.sv
module colst_gather #(
  parameter int K      = 3,
  parameter int DATA_W = 16,
  parameter int CW     = 3,
  parameter int PW     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [PW-1:0]       rd_phase,
  input  logic [DATA_W-1:0]   ram_q,
  input  logic [CW-1:0]       rd_col,
  input  logic                rd_first,
  input  logic                wb_fire,
  input  logic [K*DATA_W-1:0] wb_data,
  input  logic [PW-1:0]       wr_phase,
  output logic                st_vld,
  output logic [CW-1:0]       st_col,
  output logic [K*DATA_W-1:0] st_rd,
  output logic [DATA_W-1:0]   wr_word
);

  localparam logic [PW-1:0] LAST_PH = PW'(K - 1);

  logic                        q_vld;
  logic [PW-1:0]               q_phase;
  logic [K-1:0][DATA_W-1:0]    slots;
  logic                        st_vld_q;
  logic [CW-1:0]               st_col_q;
  logic                        st_first_q;
  logic [K-1:0][DATA_W-1:0]    hold;
  logic [CW-1:0]               hold_col;
  logic                        hold_vld;
  logic                        last_slot;
  logic                        fwd_hit;

  assign last_slot = q_vld && (q_phase == LAST_PH);

  // Align the phase tag with the registered memory output, then collect slots.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld      <= 1'b0;
      q_phase    <= '0;
      slots      <= '0;
      st_vld_q   <= 1'b0;
      st_col_q   <= '0;
      st_first_q <= 1'b0;
    end else begin
      q_vld    <= rd_en;
      q_phase  <= rd_phase;
      st_vld_q <= last_slot;
      if (q_vld) slots[q_phase] <= ram_q;
      if (last_slot) begin
        st_col_q   <= rd_col;
        st_first_q <= rd_first;
      end
    end
  end

  // Newest write-back: forwarding source and write-burst buffer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      hold_col <= '0;
      hold_vld <= 1'b0;
    end else if (wb_fire) begin
      hold     <= wb_data;
      hold_col <= st_col_q;
      hold_vld <= 1'b1;
    end
  end

  assign fwd_hit = hold_vld && (hold_col == st_col_q);
  assign wr_word = hold[wr_phase];
  assign st_vld  = st_vld_q;
  assign st_col  = st_col_q;

  for (genvar gi = 0; gi < K; gi++) begin : g_slot
    assign st_rd[gi*DATA_W +: DATA_W] = st_first_q ? '0 : (fwd_hit ? hold[gi] : slots[gi]);
  end

  // R3
  st_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |=> !st_vld);

  // R5
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && st_first_q) |-> (st_rd == '0));

  // R6
  fire_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> st_vld);

endmodule

// File: rtl/col_state_buffer.sv
module col_state_buffer
  import colst_pkg::*;
#(
  parameter int K      = 3,
  parameter int DATA_W = 16,
  parameter int LINE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            col_go,
  input  logic                            col_first,
  output logic                            st_vld,
  output logic [width_of(LINE_W)-1:0]     st_col,
  output logic [K*DATA_W-1:0]             st_rd,
  input  logic                            wb_vld,
  input  logic [K*DATA_W-1:0]             wb_data
);

  localparam int DEPTH = K * LINE_W;
  localparam int AW    = width_of(DEPTH);
  localparam int PW    = width_of(K);
  localparam int CW    = width_of(LINE_W);

  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [PW-1:0]     rd_phase;
  logic [CW-1:0]     rd_col;
  logic              rd_first;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [PW-1:0]     wr_phase;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] wr_word;
  logic              wb_fire;

  assign wb_fire = st_vld && wb_vld;

  colst_seq #(.K(K), .LINE_W(LINE_W), .CW(CW), .AW(AW), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .col_go(col_go), .col_first(col_first),
    .wb_fire(wb_fire), .wb_col(st_col),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_phase(rd_phase), .rd_col(rd_col),
    .rd_first(rd_first), .wr_en(wr_en), .wr_addr(wr_addr), .wr_phase(wr_phase)
  );

  colst_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_word),
    .re(rd_en), .raddr(rd_addr), .rdata(ram_q)
  );

  colst_gather #(.K(K), .DATA_W(DATA_W), .CW(CW), .PW(PW)) u_gather (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_phase(rd_phase), .ram_q(ram_q),
    .rd_col(rd_col), .rd_first(rd_first), .wb_fire(wb_fire), .wb_data(wb_data),
    .wr_phase(wr_phase), .st_vld(st_vld), .st_col(st_col), .st_rd(st_rd),
    .wr_word(wr_word)
  );

endmodule

// File: tb/col_state_buffer_tb.sv
`timescale 1ns/1ps
module col_state_buffer_tb;
  localparam int KS = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic go0 = 0, first0 = 0, wbv0 = 0, stv0;
  logic [KS*DW-1:0] wbd0 = '0, str0;
  logic [2:0] stc0;
  logic go1 = 0, first1 = 0, wbv1 = 0, stv1;
  logic [KS*DW-1:0] wbd1 = '0, str1;
  logic [0:0] stc1;

  col_state_buffer #(.K(KS), .DATA_W(DW), .LINE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .col_go(go0), .col_first(first0), .st_vld(stv0),
    .st_col(stc0), .st_rd(str0), .wb_vld(wbv0), .wb_data(wbd0));

  col_state_buffer #(.K(KS), .DATA_W(DW), .LINE_W(1)) u_dut_w1 (
    .clk(clk), .rst_n(rst_n), .col_go(go1), .col_first(first1), .st_vld(stv1),
    .st_col(stc1), .st_rd(str1), .wb_vld(wbv1), .wb_data(wbd1));

  int n_chk = 0, n_fail = 0;
  int colptr [2];
  logic [DW-1:0] mdl [2][8][KS];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Test datapath: K-tap recursive update.
  function automatic logic [DW-1:0] upd(input logic [DW-1:0] oi, input logic [DW-1:0] oim1,
                                        input logic [DW-1:0] x, input int i);
    if (i == 0) return oi + x;
    return oi + oim1 + DW'(i);
  endfunction

  task automatic drive(input int sel, input logic g, input logic f, input logic wv,
                       input logic [KS*DW-1:0] wd);
    if (sel == 0) begin go0 = g; first0 = f; wbv0 = wv; wbd0 = wd; end
    else          begin go1 = g; first1 = f; wbv1 = wv; wbd1 = wd; end
  endtask

  // Visits n columns at full cadence (one go every KS+1 cycles).
  task automatic stream(input int sel, input int n, input int first_n, input int skip_wb,
                        input int base_x, input string rq);
    int lw = (sel == 0) ? 8 : 1;
    int cols [64];
    int total = n * (KS + 1) + KS + 3;
    for (int s = 0; s < total; s++) begin
      logic g = 0, f = 0, wv = 0;
      logic [KS*DW-1:0] wd = '0;
      @(negedge clk);
      if ((s % (KS + 1)) == 0 && (s / (KS + 1)) < n) begin
        int j = s / (KS + 1);
        cols[j] = colptr[sel];
        colptr[sel] = (colptr[sel] + 1) % lw;
        g = 1;
        f = (j < first_n);
      end
      if (s >= KS + 2 && ((s - KS - 2) % (KS + 1)) == 0 && ((s - KS - 2) / (KS + 1)) < n) begin
        int j = (s - KS - 2) / (KS + 1);
        int c = cols[j];
        bit fz = (j < first_n);
        logic [KS*DW-1:0] exp_st = '0, nw = '0;
        logic v = (sel == 0) ? stv0 : stv1;
        int ac = (sel == 0) ? int'(stc0) : int'(stc1);
        logic [KS*DW-1:0] act = (sel == 0) ? str0 : str1;
        for (int i = 0; i < KS; i++)
          exp_st[i*DW +: DW] = fz ? '0 : mdl[sel][c][i];
        chk(v == 1'b1, "R3", "st_vld at K+1", 64'(v), 64'd1);
        chk(ac == c, "R2", "st_col", 64'(ac), 64'(c));
        chk(act == exp_st, fz ? "R5" : rq, "st_rd", 64'(act), 64'(exp_st));
        for (int i = 0; i < KS; i++)
          nw[i*DW +: DW] = upd(exp_st[i*DW +: DW], (i > 0) ? exp_st[(i-1)*DW +: DW] : '0,
                               DW'(base_x + 7 * j + 1), i);
        if (j != skip_wb) begin
          wv = 1; wd = nw;
          for (int i = 0; i < KS; i++) mdl[sel][c][i] = nw[i*DW +: DW];
        end
      end else begin
        logic v = (sel == 0) ? stv0 : stv1;
        chk(v == 1'b0, "R3", "st_vld outside pulse", 64'(v), 64'd0);
      end
      drive(sel, g, f, wv, wd);
    end
    @(negedge clk);
    drive(sel, 0, 0, 0, '0);
  endtask

  task automatic t_reset;
    chk(stv0 == 1'b0, "R1", "st_vld after reset", 64'(stv0), 64'd0);
    chk(stv1 == 1'b0, "R1", "st_vld after reset (w1)", 64'(stv1), 64'd0);
    chk(str0 == '0, "R1", "st_rd after reset", 64'(str0), 64'd0);
    chk(colptr[0] == 0, "R1", "first column index", 64'(colptr[0]), 64'd0);
  endtask

  // Write-backs asserted while no state is presented: must be ignored (R6).
  task automatic t_stray_wb;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      drive(0, 0, 0, 1, {KS{16'hDEAD}});
    end
    @(negedge clk);
    drive(0, 0, 0, 0, '0);
    chk(stv0 == 1'b0, "R6", "no state presented during stray write-back", 64'(stv0), 64'd0);
  endtask

  initial begin
    colptr[0] = 0; colptr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    stream(0, 8, 8, -1, 100, "R5");   // first line pair: zeros, state stored
    stream(0, 16, 0, -1, 200, "R4");  // two full passes, wrap of column index
    t_stray_wb();
    stream(0, 16, 0, 3, 300, "R6");   // stray + skipped write-back must not alter state
    stream(0, 8, 8, -1, 400, "R5");   // zero presentation over stored data
    stream(0, 8, 0, -1, 500, "R4");   // values written during first-flag visits
    stream(1, 10, 1, -1, 600, "R7");  // single column at full cadence: forwarding
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule